// File: doc/BRIEF.md
# Dual-Source Scanline Interrupt Counter

This block raises a level interrupt after a programmed number of counter clocks. An 8-bit down-counter reloads from a software-written latch. The counter is clocked from one of two sources. In line mode it takes a pre-filtered pulse that marks each rising edge of pattern-address bit 12, which gives one clock per rendered scanline. In cycle mode it takes a divide-by-4 prescaler running on the CPU cycle strobe.

The CPU programs the block through four write targets. A 2-bit address selects the target: bit 1 picks the group and bit 0 picks the odd or even member. One target stores the reload value. One selects the clock source and forces a reload. One disables interrupts and acknowledges a pending request. One enables interrupts. A forced reload rounds a nonzero latch value up to the next odd number, so the first interval comes out the same length on either source.

The request is a sticky level. It stays high until software acknowledges it, even while the counter keeps running.

Top module: `dual_src_line_irq`

## Requirements
- R1: After reset, `irq_req` is low. The counter, the latch, the enable, the pending request, the forced-reload flag and the prescaler are all zero, and the source is line mode. The first clock after reset therefore reloads the latch without rounding.
- R2: A write with `cfg_addr` = 0 stores `cfg_wdata` as the reload latch. It does not change the current count.
- R3: A write with `cfg_addr` = 1 does four things: it selects the source from `cfg_wdata[0]` (0 = line edge, 1 = CPU cycle), arms a forced reload, clears the counter and clears the prescaler. The interval restarts from this write.
- R4: On a counter clock with a forced reload armed, the counter loads (latch OR 1) if the latch is nonzero, or 0 if it is zero. The armed flag then clears.
- R5: On any other counter clock, a zero counter reloads the plain latch value, and a nonzero counter decrements by one.
- R6: The pending request is set when a counter clock leaves the counter at zero while interrupts are enabled. `irq_req` is high from the clock edge that performed that counter clock. With interrupts disabled, nothing is set.
- R7: A write with `cfg_addr` = 2 disables interrupts and clears the pending request. A write with `cfg_addr` = 3 enables interrupts.
- R8: In cycle mode the counter is clocked on every 4th `cpu_tick`. With latch 4, after a write of 1 to address 1 with interrupts enabled, `irq_req` rises on exactly the 24th tick.
- R9: In cycle mode, `line_edge` pulses have no effect. In line mode, `cpu_tick` neither clocks the counter nor advances the prescaler.
- R10: Once set, the pending request stays high until acknowledged, even when further counter clocks move the count away from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | CPU write strobe, one cycle per write |
| cfg_addr | input | 2 | Write target: bit 1 = group, bit 0 = odd member |
| cfg_wdata | input | 8 | Write data |
| cpu_tick | input | 1 | CPU cycle strobe, one cycle per CPU cycle |
| line_edge | input | 1 | Filtered rising-edge pulse of pattern-address bit 12 |
| irq_req | output | 1 | Level interrupt request |

## Verification
A wrong count, a missed forced reload or a missing round-up does not show up as a bad value. It shows up as `irq_req` rising one or more counter clocks too early or too late. The stimulus therefore checks the request exactly one pulse or one tick before the expected rise, and again on the expected rise itself. A prescaler that is not cleared, or that advances in the wrong mode, moves the cycle-mode rise by up to three ticks. An ignored-input bug or a lost acknowledge shows at once, on the next clock, as a spurious or stuck request.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

   // Counter clock source selected by the mode write
   typedef enum logic {
      SRC_LINE  = 1'b0,
      SRC_CYCLE = 1'b1
   } clk_src_e;

   // One-hot write strobes decoded from the 2-bit target address
   typedef struct packed {
      logic latch_wr;  // target 0
      logic force_wr;  // target 1
      logic ack_wr;    // target 2
      logic arm_wr;    // target 3
   } reg_strobe_t;

   localparam int unsigned REG_ADDR_W = 2;

endpackage

// File: rtl/lirq_decode.sv
module lirq_decode
   import lirq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [REG_ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   output reg_strobe_t           strobe,
   output logic [DATA_W-1:0]     latch_q,
   output clk_src_e              src_q,
   output logic                  en_q
);

   always_comb begin
      strobe          = '0;
      strobe.latch_wr = cfg_we && (cfg_addr == 2'd0);
      strobe.force_wr = cfg_we && (cfg_addr == 2'd1);
      strobe.ack_wr   = cfg_we && (cfg_addr == 2'd2);
      strobe.arm_wr   = cfg_we && (cfg_addr == 2'd3);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         src_q   <= SRC_LINE;
         en_q    <= 1'b0;
      end else begin
         if (strobe.latch_wr) latch_q <= cfg_wdata;
         if (strobe.force_wr) src_q <= clk_src_e'(cfg_wdata[0]);
         if (strobe.ack_wr)
            en_q <= 1'b0;
         else if (strobe.arm_wr)
            en_q <= 1'b1;
      end
   end

   // R7
   enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.arm_wr |=> en_q) and (strobe.ack_wr |=> !en_q));

   // R3
   source_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.force_wr |=> (src_q == clk_src_e'($past(cfg_wdata[0]))));

   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.latch_wr |=> $stable(latch_q));

endmodule

// File: rtl/lirq_prescale.sv
module lirq_prescale
   import lirq_pkg::*;
#(
   parameter int unsigned DIV_LOG2 = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cpu_tick,
   input  logic     line_edge,
   input  clk_src_e src,
   input  logic     clr,
   output logic     cnt_clk
);

   generate
      if (DIV_LOG2 == 0) begin : g_direct
         // No division: every CPU tick clocks the counter in cycle mode
         assign cnt_clk = (src == SRC_LINE) ? line_edge : (cpu_tick && !clr);
      end else begin : g_div
         logic [DIV_LOG2-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (clr)
               pre_q <= '0;
            else if (src == SRC_CYCLE && cpu_tick)
               pre_q <= pre_q + 1'b1;
         end

         assign cnt_clk = (src == SRC_LINE) ? line_edge
                                            : (cpu_tick && !clr && (pre_q == '1));

         // R9
         line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src == SRC_LINE && !clr) |=> $stable(pre_q));

         // R3
         pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (pre_q == '0));
      end
   endgenerate

   // R9
   cycle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_CYCLE && !cpu_tick) |-> !cnt_clk);

   // R9
   line_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_LINE && !line_edge) |-> !cnt_clk);

endmodule

// File: rtl/lirq_counter.sv
module lirq_counter #(
   parameter int unsigned CNT_W     = 8,
   parameter bit          ROUND_ODD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_clk,
   input  logic [CNT_W-1:0] latch,
   input  logic             force_wr,
   input  logic             ack_wr,
   input  logic             en,
   output logic             irq
);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] forced_val;
   logic             reload_q, reload_d;
   logic             pend_q, pend_d;
   logic             fire;

   generate
      if (ROUND_ODD) begin : g_round
         assign forced_val = latch | CNT_W'(1);
      end else begin : g_plain
         assign forced_val = latch;
      end
   endgenerate

   always_comb begin
      cnt_d    = cnt_q;
      reload_d = reload_q;
      fire     = 1'b0;
      if (force_wr) begin
         // A mode write wins over a coincident counter clock
         cnt_d    = '0;
         reload_d = 1'b1;
      end else if (cnt_clk) begin
         if (reload_q) begin
            cnt_d    = (latch == '0) ? '0 : forced_val;
            reload_d = 1'b0;
         end else if (cnt_q == '0) begin
            cnt_d = latch;
         end else begin
            cnt_d = cnt_q - 1'b1;
         end
         fire = (cnt_d == '0) && en;
      end
      pend_d = ack_wr ? 1'b0 : (pend_q || fire);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         cnt_q    <= cnt_d;
         reload_q <= reload_d;
         pend_q   <= pend_d;
      end
   end

   assign irq = pend_q;

   // R3
   force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_wr |=> (cnt_q == '0) && reload_q);

   // R5
   decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clk && !force_wr && !reload_q && cnt_q != '0)
         |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

   // R4
   reload_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clk && !force_wr && reload_q) |=> !reload_q);

   // R6
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> ($past(en) && $past(cnt_clk) && (cnt_q == '0)));

   // R10
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ack_wr) |=> pend_q);

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> !pend_q);

endmodule

// File: rtl/dual_src_line_irq.sv
module dual_src_line_irq
   import lirq_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DIV_LOG2  = 2,
   parameter bit          ROUND_ODD = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [REG_ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]      cfg_wdata,
   input  logic                  cpu_tick,
   input  logic                  line_edge,
   output logic                  irq_req
);

   localparam int unsigned DIV_RATIO = 1 << DIV_LOG2;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("dual_src_line_irq: CNT_W must lie in 2..32");
      end
      if (DIV_RATIO > 256) begin : g_bad_div
         $error("dual_src_line_irq: DIV_LOG2 must not exceed 8");
      end
   endgenerate

   reg_strobe_t      strobe;
   logic [CNT_W-1:0] latch_q;
   clk_src_e         src_q;
   logic             en_q;
   logic             cnt_clk;

   lirq_decode #(.DATA_W(CNT_W)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .strobe    (strobe),
      .latch_q   (latch_q),
      .src_q     (src_q),
      .en_q      (en_q)
   );

   lirq_prescale #(.DIV_LOG2(DIV_LOG2)) u_prescale (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_tick  (cpu_tick),
      .line_edge (line_edge),
      .src       (src_q),
      .clr       (strobe.force_wr),
      .cnt_clk   (cnt_clk)
   );

   lirq_counter #(.CNT_W(CNT_W), .ROUND_ODD(ROUND_ODD)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_clk  (cnt_clk),
      .latch    (latch_q),
      .force_wr (strobe.force_wr),
      .ack_wr   (strobe.ack_wr),
      .en       (en_q),
      .irq      (irq_req)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_req);

   // R7
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobe));

endmodule

// File: tb/dual_src_line_irq_test.sv
`timescale 1ns/1ps
module dual_src_line_irq_test;

   localparam logic [1:0] OP_WR   = 2'd0;
   localparam logic [1:0] OP_EDGE = 2'd1;
   localparam logic [1:0] OP_TICK = 2'd2;

   typedef struct packed {
      logic [1:0] op;
      logic [1:0] addr;
      logic [7:0] data;  // write data, or pulse/tick count
      logic       exp;   // expected irq_req after the pulses/ticks
      logic [3:0] req;   // requirement number for the message
   } vec_t;

   localparam int NV = 51;
   localparam vec_t TBL [NV] = '{
      '{OP_WR,   2'd0, 8'd2,  1'b0, 4'd2},   // R2 latch = 2
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},   // enable
      '{OP_EDGE, 2'd0, 8'd2,  1'b0, 4'd1},   // R1 no rounding: 0->2->1
      '{OP_EDGE, 2'd0, 8'd1,  1'b1, 4'd6},   // R6 ->0 fires
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},   // ack
      '{OP_EDGE, 2'd0, 8'd0,  1'b0, 4'd7},   // R7 cleared
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_EDGE, 2'd0, 8'd3,  1'b1, 4'd5},   // R5 0->2->1->0
      '{OP_EDGE, 2'd0, 8'd1,  1'b1, 4'd10},  // R10 count moves to 2, stays high
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},
      '{OP_EDGE, 2'd0, 8'd0,  1'b0, 4'd7},   // R7
      '{OP_EDGE, 2'd0, 8'd2,  1'b0, 4'd6},   // R6 reaches 0 while disabled
      '{OP_EDGE, 2'd0, 8'd1,  1'b0, 4'd6},
      '{OP_WR,   2'd0, 8'd2,  1'b0, 4'd2},
      '{OP_WR,   2'd1, 8'd0,  1'b0, 4'd3},   // line mode, forced reload
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_EDGE, 2'd0, 8'd3,  1'b0, 4'd4},   // R4 2|1=3 ->2 ->1
      '{OP_EDGE, 2'd0, 8'd1,  1'b1, 4'd4},   // R4 ->0
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},
      '{OP_WR,   2'd0, 8'd0,  1'b0, 4'd2},
      '{OP_WR,   2'd1, 8'd0,  1'b0, 4'd3},
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_EDGE, 2'd0, 8'd1,  1'b1, 4'd4},   // R4 zero latch stays 0
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_EDGE, 2'd0, 8'd1,  1'b1, 4'd5},   // R5 zero reloads latch 0
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},
      '{OP_WR,   2'd0, 8'd4,  1'b0, 4'd2},
      '{OP_WR,   2'd1, 8'd1,  1'b0, 4'd3},   // cycle mode
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_TICK, 2'd0, 8'd23, 1'b0, 4'd8},   // R8
      '{OP_TICK, 2'd0, 8'd1,  1'b1, 4'd8},   // R8 24th tick
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_EDGE, 2'd0, 8'd20, 1'b0, 4'd9},   // R9 edges ignored
      '{OP_TICK, 2'd0, 8'd19, 1'b0, 4'd9},   // 0->4 then 4 clocks
      '{OP_TICK, 2'd0, 8'd1,  1'b1, 4'd9},
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_WR,   2'd1, 8'd1,  1'b0, 4'd3},
      '{OP_TICK, 2'd0, 8'd10, 1'b0, 4'd3},   // prescaler mid-way
      '{OP_WR,   2'd1, 8'd1,  1'b0, 4'd3},   // restart
      '{OP_TICK, 2'd0, 8'd23, 1'b0, 4'd3},   // R3 prescaler cleared
      '{OP_TICK, 2'd0, 8'd1,  1'b1, 4'd3},
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7},
      '{OP_WR,   2'd0, 8'd0,  1'b0, 4'd2},
      '{OP_WR,   2'd1, 8'd0,  1'b0, 4'd3},   // line mode
      '{OP_WR,   2'd3, 8'd0,  1'b0, 4'd7},
      '{OP_TICK, 2'd0, 8'd40, 1'b0, 4'd9},   // R9 ticks ignored
      '{OP_EDGE, 2'd0, 8'd1,  1'b1, 4'd9},
      '{OP_WR,   2'd2, 8'd0,  1'b0, 4'd7}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       cpu_tick = 1'b0;
   logic       line_edge = 1'b0;
   logic       irq_req;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_src_line_irq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cpu_tick  (cpu_tick),
      .line_edge (line_edge),
      .irq_req   (irq_req)
   );

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         line_edge = 1'b1;
      end
      @(negedge clk);
      line_edge = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cpu_tick = 1'b1;
      end
      @(negedge clk);
      cpu_tick = 1'b0;
   endtask

   task automatic check(input string tag, input logic exp);
      total++;
      if (irq_req !== exp) begin
         bad++;
         $display("FAIL %s irq_req actual=%b expected=%b", tag, irq_req, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", 1'b0);

      for (int k = 0; k < NV; k++) begin
         case (TBL[k].op)
            OP_WR:   wr(TBL[k].addr, TBL[k].data);
            OP_EDGE: begin
               edges(int'(TBL[k].data));
               check($sformatf("R%0d row %0d", TBL[k].req, k), TBL[k].exp);
            end
            default: begin
               ticks(int'(TBL[k].data));
               check($sformatf("R%0d row %0d", TBL[k].req, k), TBL[k].exp);
            end
         endcase
      end

      // Directed: reset drops a pending request and clears the enable (R1)
      wr(2'd3, 8'd0);
      edges(1);
      check("R6 fire before reset", 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears request", 1'b0);
      rst_n = 1'b1;
      edges(1);
      check("R1 enable cleared by reset", 1'b0);
      wr(2'd3, 8'd0);
      edges(1);
      check("R1 latch zero after reset", 1'b1);
      wr(2'd2, 8'd0);
      check("R7 final ack", 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule